// File: doc/BRIEF.md
# Double-Data-Rate Synchronous SRAM Command and Data Path

This block models the command and data path of a synchronous SRAM that moves two data words per clock cycle. On every rising edge it samples an address, a load/advance control, a write strobe and three chip enables, and turns them into a read, a write, a burst continuation or a deselect cycle. Each access covers a pair of words. The external address selects the pair. The word inside the pair is given by the clock phase: even word on the rising-edge beat, odd word on the falling-edge beat. The storage array is small and lives inside the block.

Writes follow late-write timing. The data pair is taken on the rising edge after the command and on the falling edge after that. The block then merges the pair into the rising-edge domain and stores it one cycle later. Reads are looked up during the cycle after the command is sampled, and drive the even word in the high phase and the odd word in the low phase of the next cycle. A write that has not yet reached the array is forwarded to a read of the same pair, so the read and write paths stay coherent. The block also gives an echo-clock enable that depends only on the two programmable-polarity enables.

Top module: `ddr_sram_core`

## Requirements
- R1: With all enables active and `adv_i` low at a rising edge, `we_ni` high starts a read of pair `addr_i`. Word 2a (the pair's low half) appears on `q_o` in the high phase of the cycle that begins at the next rising edge. Word 2a+1 appears in the low phase of that same cycle.
- R2: With all enables active and `adv_i` and `we_ni` both low at rising edge E, the block writes pair `addr_i`. Word 2a is taken from `d_i` at the rising edge after E. Word 2a+1 is taken at the falling edge that follows. A later read returns both words.
- R3: The block is selected only when `ce1_ni` is 0, `ce2_i` equals `ce2_pol_i` and `ce3_i` equals `ce3_pol_i`. Any other combination is a deselect cycle: the array is not written and `q_oe_o` stays low.
- R4: While selected, `adv_i` high after a read or write cycle repeats that operation at the previous pair address with bit 0 inverted. A four-word burst therefore wraps every two cycles. `we_ni` is ignored in this case. `adv_i` high after a deselect cycle, or right after reset, is a deselect.
- R5: `q_oe_o` is high for exactly the cycle that follows a read or read-continue cycle, and is low otherwise. `q_o` is all zeros whenever `q_oe_o` is low.
- R6: `echo_en_o` is high in the cycle after a rising edge at which both `ce2_i` and `ce3_i` are at their programmed active level. `ce1_ni` has no effect on it.
- R7: A read of a pair, issued in the cycle right after a write to the same pair, returns the newly written words.
- R8: After reset, `q_oe_o` and `echo_en_o` are low, `q_o` is zero, and no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word-pair address |
| adv_i | input | 1 | 0 loads a new address, 1 continues the burst |
| we_ni | input | 1 | 0 write, 1 read (on load cycles only) |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable with programmable polarity |
| ce3_i | input | 1 | Chip enable with programmable polarity |
| ce2_pol_i | input | 1 | Active level of `ce2_i` (static) |
| ce3_pol_i | input | 1 | Active level of `ce3_i` (static) |
| d_i | input | DATA_W | Write data, sampled on both clock edges |
| q_o | output | DATA_W | Read data, even word in high phase, odd word in low phase |
| q_oe_o | output | 1 | Read data valid, low means the bus is high impedance |
| echo_en_o | output | 1 | Echo clock enable |

## Verification
The assertions assume the two polarity inputs hold steady between the edges they matter at. They also assume no data-beat timing beyond a rising-edge and falling-edge sample of `d_i`. The stimulus keeps to this: it changes the polarity programs only between test phases, and it moves `d_i` only 2 ns after each clock edge. Random cycles mix loads, continues and raw random enable values, including mismatches against the programmed polarity. Directed sequences cover forwarding from a write to the next read, burst wrap, writes blocked by a deselect, and a continue issued right after reset.

// File: rtl/ddr_sram_pkg.sv
package ddr_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/ddr_sram_decode.sv
module ddr_sram_decode
  import ddr_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_i,
  input  logic              ce2_pol_i,
  input  logic              ce3_pol_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              echo_en_o
);
  localparam logic [ADDR_W-1:0] BURST_STEP = ADDR_W'(1);

  logic              ce23_act;
  logic              sel;
  op_e               op_d;
  logic [ADDR_W-1:0] addr_d;

  assign ce23_act = (ce2_i == ce2_pol_i) && (ce3_i == ce3_pol_i);
  assign sel      = !ce1_ni && ce23_act;

  always_comb begin
    op_d   = OP_IDLE;
    addr_d = op_o == OP_IDLE ? addr_i : addr_o;
    if (sel) begin
      if (!adv_i) begin
        op_d   = we_ni ? OP_RD : OP_WR;
        addr_d = addr_i;
      end else if (op_o != OP_IDLE) begin
        // burst continue: linear order, wraps after two pairs
        op_d   = op_o;
        addr_d = addr_o ^ BURST_STEP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o      <= OP_IDLE;
      addr_o    <= '0;
      echo_en_o <= 1'b0;
    end else begin
      op_o      <= op_d;
      addr_o    <= addr_d;
      echo_en_o <= ce23_act;
    end
  end
endmodule

// File: rtl/ddr_sram_wcap.sv
module ddr_sram_wcap
  import ddr_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] beat0_o,
  output logic [DATA_W-1:0] beat1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_vld_o  <= 1'b0;
      wr_addr_o <= '0;
      beat0_o   <= '0;
    end else begin
      wr_vld_o  <= op_i == OP_WR;
      wr_addr_o <= addr_i;
      beat0_o   <= d_i;
    end
  end

  // odd word: falling-edge sample, consumed at the next rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat1_o <= '0;
    else         beat1_o <= d_i;
  end
endmodule

// File: rtl/ddr_sram_rdpath.sv
module ddr_sram_rdpath
  import ddr_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] beat0_i,
  input  logic [DATA_W-1:0] beat1_i,
  output logic [DATA_W-1:0] q_o,
  output logic              q_oe_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAIR_W = 2 * DATA_W;

  logic [PAIR_W-1:0] mem [DEPTH];
  logic [PAIR_W-1:0] rd_word;
  logic              fwd_hit;
  logic [DATA_W-1:0] q0_q, q1_q, q1_n;
  logic              oe_q;

  always_ff @(posedge clk_i) begin
    if (wr_vld_i) mem[wr_addr_i] <= {beat1_i, beat0_i};
  end

  // late-write forwarding keeps the read path coherent
  assign fwd_hit = wr_vld_i && (wr_addr_i == addr_i);
  assign rd_word = fwd_hit ? {beat1_i, beat0_i} : mem[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q0_q <= '0;
      q1_q <= '0;
      oe_q <= 1'b0;
    end else begin
      oe_q <= op_i == OP_RD;
      if (op_i == OP_RD) begin
        q0_q <= rd_word[DATA_W-1:0];
        q1_q <= rd_word[PAIR_W-1:DATA_W];
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q1_n <= '0;
    else         q1_n <= q1_q;
  end

  assign q_oe_o = oe_q;
  assign q_o    = oe_q ? (clk_i ? q0_q : q1_n) : '0;
endmodule

// File: rtl/ddr_sram_core.sv
module ddr_sram_core
  import ddr_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_i,
  input  logic              ce2_pol_i,
  input  logic              ce3_pol_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              q_oe_o,
  output logic              echo_en_o
);
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic              wr_vld;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] beat0, beat1;

  ddr_sram_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .adv_i     (adv_i),
    .we_ni     (we_ni),
    .ce1_ni    (ce1_ni),
    .ce2_i     (ce2_i),
    .ce3_i     (ce3_i),
    .ce2_pol_i (ce2_pol_i),
    .ce3_pol_i (ce3_pol_i),
    .op_o      (cmd_op),
    .addr_o    (cmd_addr),
    .echo_en_o (echo_en_o)
  );

  ddr_sram_wcap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (cmd_op),
    .addr_i    (cmd_addr),
    .d_i       (d_i),
    .wr_vld_o  (wr_vld),
    .wr_addr_o (wr_addr),
    .beat0_o   (beat0),
    .beat1_o   (beat1)
  );

  ddr_sram_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (cmd_op),
    .addr_i    (cmd_addr),
    .wr_vld_i  (wr_vld),
    .wr_addr_i (wr_addr),
    .beat0_i   (beat0),
    .beat1_i   (beat1),
    .q_o       (q_o),
    .q_oe_o    (q_oe_o)
  );
endmodule

// File: rtl/ddr_sram_chk.sv
module ddr_sram_chk
  import ddr_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adv_i,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_i,
  input logic              ce2_pol_i,
  input logic              ce3_pol_i,
  input op_e               cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] q_o,
  input logic              q_oe_o,
  input logic              echo_en_o
);
  logic e23;
  assign e23 = (ce2_i == ce2_pol_i) && (ce3_i == ce3_pol_i);

  a_r6_echo_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e23 |=> echo_en_o);
  a_r6_echo_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !e23 |=> !echo_en_o);
  a_r3_ce1_blocks_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce1_ni |-> ##2 !q_oe_o);
  a_r5_oe_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_op == OP_RD) |=> q_oe_o);
  a_r5_oe_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_op != OP_RD) |=> !q_oe_o);
  a_r5_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_oe_o |-> (q_o == '0));
  a_r4_cont_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce1_ni && e23 && adv_i && cmd_op != OP_IDLE) |=>
      (cmd_addr == ($past(cmd_addr) ^ ADDR_W'(1))) && (cmd_op == $past(cmd_op)));
  a_r4_cont_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cmd_op == OP_IDLE) |=> (cmd_op == OP_IDLE));
endmodule

bind ddr_sram_core ddr_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .adv_i     (adv_i),
  .ce1_ni    (ce1_ni),
  .ce2_i     (ce2_i),
  .ce3_i     (ce3_i),
  .ce2_pol_i (ce2_pol_i),
  .ce3_pol_i (ce3_pol_i),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr),
  .q_o       (q_o),
  .q_oe_o    (q_oe_o),
  .echo_en_o (echo_en_o)
);

// File: tb/ddr_sram_core_bench.sv
module ddr_sram_core_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NP = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adv_i = 1'b0, we_ni = 1'b1, ce1_ni = 1'b1;
  logic          ce2_i = 1'b0, ce3_i = 1'b0, ce2_pol_i = 1'b1, ce3_pol_i = 1'b1;
  logic [DW-1:0] d_i = '0;
  logic [DW-1:0] q_o;
  logic          q_oe_o, echo_en_o;

  always #5 clk_i = ~clk_i;

  ddr_sram_core #(.ADDR_W(AW), .DATA_W(DW)) u_ddr_sram_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .adv_i(adv_i),
    .we_ni(we_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_i(ce3_i),
    .ce2_pol_i(ce2_pol_i), .ce3_pol_i(ce3_pol_i), .d_i(d_i),
    .q_o(q_o), .q_oe_o(q_oe_o), .echo_en_o(echo_en_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model: ideal coherent pair memory; op 0 idle, 1 read, 2 write
  logic [2*DW-1:0] mdl [NP];
  int            cur_op = 0, prv_op = 0;
  logic [AW-1:0] cur_a = '0, prv_a = '0;
  logic [DW-1:0] cur_b0, cur_b1, prv_b0, prv_b1;
  string         cur_tag = "R1", prv_tag = "R1";
  string         force_tag = "";
  bit            exp_echo = 0;
  // inputs staged for the next edge
  logic [AW-1:0] n_addr = '0;
  logic          n_adv = 1'b0, n_we = 1'b1, n_ce1 = 1'b1, n_ce2 = 1'b0, n_ce3 = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_decode();
    bit act, e23;
    int op;
    logic [AW-1:0] a;
    e23 = (ce2_i == ce2_pol_i) && (ce3_i == ce3_pol_i);
    act = !ce1_ni && e23;
    op = 0; a = cur_a;
    prv_op = cur_op; prv_a = cur_a; prv_b0 = cur_b0; prv_b1 = cur_b1; prv_tag = cur_tag;
    cur_tag = "R1";
    if (act && !adv_i) begin
      op = we_ni ? 1 : 2; a = addr_i;
    end else if (act && adv_i && prv_op != 0) begin
      op = prv_op; a = prv_a ^ AW'(1); cur_tag = "R4";
    end
    if (op == 2) begin
      cur_b0 = DW'($urandom); cur_b1 = DW'($urandom);
      mdl[a] = {cur_b1, cur_b0};
      cur_tag = "R2";
    end else if (op == 1) begin
      {cur_b1, cur_b0} = mdl[a];
      if (prv_op == 2 && prv_a == a) cur_tag = "R7";
    end
    if (force_tag != "") cur_tag = force_tag;
    cur_op = op; cur_a = a;
    exp_echo = e23;
  endtask

  // one clock cycle: stimulus for the following edge is the staged n_* set
  task automatic cyc();
    @(posedge clk_i);
    model_decode();
    #2;
    addr_i = n_addr; adv_i = n_adv; we_ni = n_we; ce1_ni = n_ce1; ce2_i = n_ce2; ce3_i = n_ce3;
    d_i = (prv_op == 2) ? prv_b1 : DW'($urandom);
    #2;
    chk("R5", DW'(q_oe_o), DW'(prv_op == 1));
    chk("R6", DW'(echo_en_o), DW'(exp_echo));
    chk(prv_op == 1 ? prv_tag : "R5", q_o, prv_op == 1 ? prv_b0 : '0);
    #3;
    d_i = (cur_op == 2) ? cur_b0 : DW'($urandom);
    #2;
    chk(prv_op == 1 ? prv_tag : "R5", q_o, prv_op == 1 ? prv_b1 : '0);
  endtask

  task automatic stage(input bit ce1a, input bit ce2a, input bit ce3a, input bit adv,
                       input bit we_n, input logic [AW-1:0] a);
    n_ce1 = !ce1a; n_ce2 = ce2a ? ce2_pol_i : !ce2_pol_i; n_ce3 = ce3a ? ce3_pol_i : !ce3_pol_i;
    n_adv = adv; n_we = we_n; n_addr = a;
    cyc();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NP; i++) mdl[i] = '0;
    cur_b0 = '0; cur_b1 = '0; prv_b0 = '0; prv_b1 = '0;
    #23;
    // R8: reset state
    chk("R8", DW'(q_oe_o), '0);
    chk("R8", DW'(echo_en_o), '0);
    chk("R8", q_o, '0);
    // R8 / R4: a continue straight out of reset must stay idle
    n_ce1 = 1'b0; n_ce2 = 1'b1; n_ce3 = 1'b1; n_adv = 1'b1; n_we = 1'b1;
    ce1_ni = 1'b0; ce2_i = 1'b1; ce3_i = 1'b1; adv_i = 1'b1;
    @(negedge clk_i); rst_ni = 1'b1;
    force_tag = "R8";
    stage(1, 1, 1, 1, 1, '0);
    stage(1, 1, 1, 1, 1, '0);
    force_tag = "";
    // R2: fill every pair, then read all back
    for (int i = 0; i < NP; i++) stage(1, 1, 1, 0, 0, AW'(i));
    force_tag = "R2";
    for (int i = 0; i < NP; i++) stage(1, 1, 1, 0, 1, AW'(i));
    force_tag = "";
    // R7: read straight after a write to the same pair
    for (int i = 0; i < 4; i++) begin
      stage(1, 1, 1, 0, 0, AW'(3 * i));
      stage(1, 1, 1, 0, 1, AW'(3 * i));
    end
    // R4: write burst with we_ni toggling on continues, then read burst wrap
    stage(1, 1, 1, 0, 0, AW'(6));
    stage(1, 1, 1, 1, 1, '0);
    stage(1, 1, 1, 1, 0, '0);
    stage(1, 1, 1, 0, 1, AW'(7));
    stage(1, 1, 1, 1, 0, '0);
    stage(1, 1, 1, 1, 1, '0);
    stage(1, 1, 1, 1, 1, '0);
    // R3: deselected write (via ce1) must not change the array; echo keeps running
    force_tag = "R3";
    stage(0, 1, 1, 0, 0, AW'(9));
    stage(0, 1, 1, 1, 0, AW'(9));
    stage(1, 1, 1, 0, 1, AW'(9));
    stage(1, 0, 1, 0, 0, AW'(9));
    stage(1, 1, 0, 0, 0, AW'(9));
    stage(1, 1, 1, 0, 1, AW'(9));
    force_tag = "";
    stage(1, 1, 1, 0, 1, AW'(1));
    // flipped polarity programs: R3, R6
    ce2_pol_i = 1'b0; ce3_pol_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      stage(1, 1, 1, 0, i % 2, AW'(i));
      stage(1, 0, 1, 0, 0, AW'(i));
    end
    ce2_pol_i = 1'b1; ce3_pol_i = 1'b0;
    // random traffic with raw enable values
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      n_ce1 = (r < 8);
      n_ce2 = (r >= 8 && r < 14) ? !ce2_pol_i : ce2_pol_i;
      n_ce3 = (r >= 14 && r < 18) ? !ce3_pol_i : ce3_pol_i;
      n_adv = ($urandom_range(0, 2) == 0);
      n_we = $urandom_range(0, 1);
      n_addr = AW'($urandom);
      cyc();
      if (i == 1500) begin ce2_pol_i = 1'b0; ce3_pol_i = 1'b1; end
    end
    stage(0, 1, 1, 0, 1, '0);
    stage(0, 1, 1, 0, 1, '0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule